// File: doc/BRIEF.md
# Gray-Coded Iteration Run Controller

This block sequences a multi-cycle iterative datapath, such as a radix-4 recoded multiplier, so that a synchronous host can treat that datapath as one combinational step. The host raises a request. The controller then raises a run output, which stands in for a locally started fast oscillator. While run is high, the controller produces a one-cycle iteration strobe every programmable number of cycles. After the required number of strobes it drops run and pulses done. The strobe period comes from a small divider. It models a delay element that can be tuned after fabrication, and it can be rewritten only while the controller is idle.

The number of iterations follows from the operand width: half the width in recoding steps plus two steps of fixed overhead. A narrow mode, chosen at request time, uses a shorter operand width for a coefficient that needs less range and cuts the run accordingly. The four control states sit on a Gray cycle, so each transition flips exactly one state bit. The run output is a single state bit, which keeps it free of decode hazards.

Top module: `iter_run_ctl`

## Requirements
- R1: During and after reset, until the first request, run, iter_tick and done are all low.
- R2: A request taken while idle raises run in the next cycle, and no strobe occurs in that first run cycle.
- R3: With period field P, strobes recur every P+1 cycles while run is high; the first strobe comes P+1 cycles after run rises, and P=0 gives a strobe in every cycle after the first run cycle.
- R4: With req_narrow low at the request, exactly WORD_W/2+2 strobes occur (14 at defaults), and run is low in the cycle right after the last strobe.
- R5: With req_narrow high at the request, exactly NARROW_W/2+2 strobes occur (7 at defaults).
- R6: done is high for exactly one cycle, the cycle right after the last strobe, with run low in that cycle; a request in the following cycle is accepted.
- R7: A request made while run is high or done is high has no effect on the run in progress and does not start another run.
- R8: cfg_wr loads cfg_period only while idle; a write at the same edge as a request applies to that run, and a write while busy is dropped.
- R9: Every state change flips exactly one state bit, and run is taken straight from one state bit.
- R10: run is never high in the idle state, and iter_tick is never high while run is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast local clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request to start a run |
| req_narrow | input | 1 | Selects the short iteration count for this request |
| cfg_wr | input | 1 | Period write strobe, honoured only when idle |
| cfg_period | input | PER_W | Period field P; the strobe interval is P+1 cycles |
| run | output | 1 | High while the iteration clock is enabled |
| iter_tick | output | 1 | One-cycle iteration strobe |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest cases to reach from the ports are requests and period writes that land exactly on the done cycle or in the first cycle after it. At those edges the controller changes from busy to idle. The stimulus holds req high across a whole run, so that a request sits on the done cycle and again on the idle cycle that follows. It also issues period writes inside runs and together with a request. A behavioural model that counts cycles since run rose predicts run, strobe and done for every cycle, so any request or write accepted one cycle early or late shows up as a mismatch.

// File: rtl/iter_run_ctl_pkg.sv
package iter_run_ctl_pkg;

    // Gray cycle: IDLE -> ARM -> RUN -> FIN -> IDLE, one bit per step.
    // Bit 0 is the run enable.
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ARM  = 2'b01,
        ST_RUN  = 2'b11,
        ST_FIN  = 2'b10
    } ctl_state_e;

    function automatic int iter_count(input int width);
        return width / 2 + 2;
    endfunction

    function automatic logic run_bit(input ctl_state_e s);
        return s[0];
    endfunction

endpackage

// File: rtl/iter_run_div.sv
module iter_run_div #(
    parameter int PER_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PER_W-1:0] per,
    output logic             tick
);
    logic [PER_W-1:0] cnt_q;

    assign tick = en && (cnt_q == per);

    always_ff @(posedge clk) begin
        if (rst || !en || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/iter_run_cnt.sv
module iter_run_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] target,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    assign last = tick && (cnt_q == target - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/iter_run_fsm.sv
module iter_run_fsm
    import iter_run_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       last,
    output ctl_state_e state
);
    ctl_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (req)  nxt = ST_ARM;
            ST_ARM:            nxt = ST_RUN;
            ST_RUN:  if (last) nxt = ST_FIN;
            ST_FIN:            nxt = ST_IDLE;
            default:           nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end
endmodule

// File: rtl/iter_run_ctl.sv
module iter_run_ctl
    import iter_run_ctl_pkg::*;
#(
    parameter int WORD_W   = 24,
    parameter int NARROW_W = 10,
    parameter int PER_W    = 4,
    parameter int DEF_PER  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             req_narrow,
    input  logic             cfg_wr,
    input  logic [PER_W-1:0] cfg_period,
    output logic             run,
    output logic             iter_tick,
    output logic             done
);
    localparam int FULL_ITER   = iter_count(WORD_W);
    localparam int NARROW_ITER = iter_count(NARROW_W);
    localparam int CNT_W       = $clog2(FULL_ITER + 1);
    localparam logic [CNT_W-1:0] FULL_T   = CNT_W'(FULL_ITER);
    localparam logic [CNT_W-1:0] NARROW_T = CNT_W'(NARROW_ITER);

    ctl_state_e       st_q;
    logic [PER_W-1:0] per_q;
    logic [CNT_W-1:0] tgt_q;
    logic             idle;
    logic             last;

    assign idle = (st_q == ST_IDLE);

    // Period and iteration target are only loaded while idle.
    always_ff @(posedge clk) begin
        if (rst) begin
            per_q <= PER_W'(DEF_PER);
            tgt_q <= FULL_T;
        end else if (idle) begin
            if (cfg_wr) per_q <= cfg_period;
            if (req)    tgt_q <= req_narrow ? NARROW_T : FULL_T;
        end
    end

    iter_run_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .last  (last),
        .state (st_q)
    );

    iter_run_div #(.PER_W(PER_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .en   (st_q == ST_RUN),
        .per  (per_q),
        .tick (iter_tick)
    );

    iter_run_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr    (st_q == ST_ARM),
        .tick   (iter_tick),
        .target (tgt_q),
        .last   (last)
    );

    assign run  = run_bit(st_q);
    assign done = (st_q == ST_FIN);
endmodule

// File: rtl/iter_run_ctl_chk.sv
module iter_run_ctl_chk
    import iter_run_ctl_pkg::*;
#(
    parameter int PER_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             req,
    input ctl_state_e       state,
    input logic [PER_W-1:0] per,
    input logic             run,
    input logic             iter_tick,
    input logic             done
);
    AST_GRAY_STEP: assert property (@(posedge clk) disable iff (rst)
        $countones(state ^ $past(state)) <= 1); // R9

    AST_START_RUN: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && req) |=> (run && !iter_tick)); // R2

    AST_DROP_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(run) |-> done); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !run)); // R6

    AST_DONE_NO_RUN: assert property (@(posedge clk) disable iff (rst)
        done |-> !run); // R6

    AST_TICK_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        iter_tick |-> run); // R10

    AST_PER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> $stable(per)); // R8

    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (run && !iter_tick) |=> run); // R7
endmodule

bind iter_run_ctl iter_run_ctl_chk #(.PER_W(PER_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .state     (st_q),
    .per       (per_q),
    .run       (run),
    .iter_tick (iter_tick),
    .done      (done)
);

// File: tb/iter_run_ctl_bench.sv
module iter_run_ctl_bench;
    localparam int WORD_W   = 24;
    localparam int NARROW_W = 10;
    localparam int PER_W    = 4;
    localparam int DEF_PER  = 3;
    localparam int FULL_N   = WORD_W / 2 + 2;
    localparam int NARROW_N = NARROW_W / 2 + 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req = 1'b0;
    logic             req_narrow = 1'b0;
    logic             cfg_wr = 1'b0;
    logic [PER_W-1:0] cfg_period = '0;
    logic             run, iter_tick, done;

    int total = 0;
    int bad   = 0;
    int ticks_seen = 0;
    int cycles = 0;

    // reference model state
    int m_t   = -1;   // cycles since run rose, -1 when not running
    bit m_fin = 1'b0;
    int m_tgt = FULL_N;
    int m_per = DEF_PER + 1;

    always #2.5 clk = ~clk;

    iter_run_ctl #(
        .WORD_W(WORD_W), .NARROW_W(NARROW_W), .PER_W(PER_W), .DEF_PER(DEF_PER)
    ) u_iter_run_ctl (
        .clk(clk), .rst(rst), .req(req), .req_narrow(req_narrow),
        .cfg_wr(cfg_wr), .cfg_period(cfg_period),
        .run(run), .iter_tick(iter_tick), .done(done)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // model step on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_t = -1; m_fin = 1'b0; m_tgt = FULL_N; m_per = DEF_PER + 1;
        end else if (m_fin) begin
            m_fin = 1'b0;
        end else if (m_t >= 0) begin
            if (m_t == m_tgt * m_per) begin
                m_t = -1; m_fin = 1'b1;
            end else begin
                m_t++;
            end
        end else begin
            if (cfg_wr) m_per = int'(cfg_period) + 1;
            if (req) begin
                m_t = 0;
                m_tgt = req_narrow ? NARROW_N : FULL_N;
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (iter_tick) ticks_seen++;
        if (rst) begin
            check("R1 run in reset", run, 0);
            check("R1 done in reset", done, 0);
            check("R1 tick in reset", iter_tick, 0);
        end else if (m_fin) begin
            check("R6 done", done, 1);
            check("R6 run low on done", run, 0);
            check("R6 tick", iter_tick, 0);
        end else if (m_t >= 0) begin
            check("R2/R7 run high", run, 1);
            check("R3 strobe timing", iter_tick,
                  (m_t >= 1 && (m_t % m_per) == 0) ? 1 : 0);
            check("R6 done while running", done, 0);
        end else begin
            check("R10 run while idle", run, 0);
            check("R10 tick while idle", iter_tick, 0);
            check("R6 done while idle", done, 0);
        end
        if (cycles > 100000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic do_op(input bit narrow, input int exp_ticks, input string tag);
        @(negedge clk);
        ticks_seen = 0;
        req = 1'b1; req_narrow = narrow;
        @(negedge clk);
        req = 1'b0; req_narrow = 1'b0;
        while (!done) @(negedge clk);
        @(posedge clk);
        check(tag, ticks_seen, exp_ticks);
    endtask

    task automatic set_period(input int p);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_period = PER_W'(p);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);   // R1: idle after reset checked per cycle

        do_op(1'b0, FULL_N, "R4 full-mode strobe count");
        do_op(1'b1, NARROW_N, "R5 narrow-mode strobe count");

        set_period(0);               // R3: strobe every cycle
        do_op(1'b0, FULL_N, "R3 period zero count");
        set_period(7);
        do_op(1'b1, NARROW_N, "R3 period seven count");

        // R7/R8: requests and period writes while busy are dropped
        @(negedge clk);
        ticks_seen = 0;
        req = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            cfg_wr = 1'b1; cfg_period = PER_W'(i % 3);
            req_narrow = 1'b1;
            @(negedge clk);
        end
        req = 1'b0; cfg_wr = 1'b0; req_narrow = 1'b0;
        while (!done) @(negedge clk);
        @(posedge clk);
        check("R7 busy requests ignored, full count kept", ticks_seen, FULL_N);

        // R8: write together with request applies to that run
        @(negedge clk);
        cfg_wr = 1'b1; cfg_period = PER_W'(1);
        ticks_seen = 0;
        req = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; req = 1'b0;
        while (!done) @(negedge clk);
        @(posedge clk);
        check("R8 write with request count", ticks_seen, FULL_N);

        // R6/R7/R9: req held across done and the following idle cycle
        @(negedge clk);
        ticks_seen = 0;
        req = 1'b1;
        while (!done) @(negedge clk);
        @(negedge clk);              // idle cycle: req accepted again
        @(negedge clk);
        check("R6 re-accept after done", run, 1);
        req = 1'b0;
        while (!done) @(negedge clk);
        @(posedge clk);
        check("R9 two clean runs strobe total", ticks_seen, 2 * FULL_N);

        repeat (4) @(negedge clk);
        check("R10 idle at end", run, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule